// File: doc/BRIEF.md
# Rolling Shutter Frame Sequencer

This block paces the readout of a rolling-shutter pixel array. A single clock enable marks the internal row-timing ticks. On each enabled tick the block advances through a row made of three parts: a programmable pre-delay, a fixed operation window and a shift-out phase. In the fixed window the row's charge moves to the sampling stage, and in the shift-out phase the pixels leave the array. Rows step through a programmable scan window. Each frame closes with a programmable number of idle row periods. A second pointer runs a set number of row slots ahead of readout and issues row-reset strobes, which shortens the exposure to that lead times the row period.

Three scan orderings are supported. The first reads every row. The second alternates fields of even and odd offsets. The third reads every other row. The programmed exposure lead is clamped to a limit that depends on the ordering, and a sticky flag records that a clamp occurred. All settings are captured together at a frame boundary, so software may rewrite them at any time.

Top module: `rs_frame_seq`

## Requirements
- R1: Nothing advances on a cycle with `ce` low, and no strobe is raised on such a cycle. One row period lasts ROP_CYCLES + `rowDly` enabled cycles. ROP_CYCLES defaults to 780.
- R2: Let p be the enabled-cycle index inside a row, starting at 0. On a readout row, `xferStb` pulses at p = `rowDly`. `lineValid` is high for p from `rowDly` + XFER_CYCLES up to the end of the row. Neither is ever high on an idle row.
- R3: The window holds N = `winEnd` - `winStart` + 1 rows. With `scanMode` = 0 (and also 3), each frame reads rows `winStart` through `winEnd` in ascending order. The next frame starts again at `winStart`.
- R4: A frame is the readout rows followed by `frmDly` idle row periods. `frameStart` is high for exactly the first enabled cycle of the first row of each frame.
- R5: With `scanMode` = 1, frames alternate between two fields. The first field after reset reads offsets 0, 2, 4, … from `winStart`, which is ceil(N/2) rows. The next field reads offsets 1, 3, …, which is floor(N/2) rows.
- R6: With `scanMode` = 2, every frame reads offsets 0, 2, 4, … from `winStart`, which is ceil(N/2) rows.
- R7: All settings are captured while `rst` is high and at the end of each frame's last row period. A change made mid-frame first takes effect on the next frame.
- R8: A lead L is derived from `intRows`. On the first enabled cycle of each row slot s, `rowRstStb` pulses for the readout row of slot s + L. When that index passes the end of the frame (readout rows plus idle slots), it wraps into the next frame. That next frame uses the next field's parity in mode 1 and the current settings. No strobe is issued when the target is an idle slot. `resetRow` carries the target row.
- R9: The row limit is N + `frmDly` in mode 0/3, N + 2·`frmDly` in mode 1 and N + floor(`frmDly`/2) in mode 2. An `intRows` above the limit is replaced by the limit. The lead L is the result in mode 0/3 and half of it, rounded down, in modes 1 and 2.
- R10: `cfgErr` goes high on the clock edge after a frame whose captured `intRows` exceeded its limit has been active for one cycle. It then stays high until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; settings captured while high |
| ce | input | 1 | Row-timing tick enable |
| winStart | input | ROW_W | First row of the scan window |
| winEnd | input | ROW_W | Last row of the scan window |
| rowDly | input | RDLY_W | Extra cycles at the start of each row |
| frmDly | input | FDLY_W | Idle row periods after each frame |
| intRows | input | ITIME_W | Exposure lead in rows |
| scanMode | input | 2 | 0 all rows, 1 alternating fields, 2 every other row, 3 as 0 |
| readRow | output | ROW_W | Row being read out |
| resetRow | output | ROW_W | Row targeted by the reset strobe |
| xferStb | output | 1 | Pixel transfer strobe |
| lineValid | output | 1 | High while the row's pixels shift out |
| rowRstStb | output | 1 | Row reset strobe |
| frameStart | output | 1 | First cycle of a frame |
| cfgErr | output | 1 | Sticky exposure-clamp flag |

## Verification
The bench targets several edge cases, each with the error a faulty design would show. A one-row window must wrap every frame, or the row address would run off the window. A zero row delay puts the transfer strobe on the first cycle of the row, where a design could drop it or double it with the frame start. A reset lead that reaches past the idle rows into the next field must land on the other parity, or it would reset rows that are not read in that field. An over-limit lead must be clamped and flagged, and the flag must survive a later legal setting. Irregular `ce` gaps show up as stretched rows if a counter ignores the enable. Mid-frame rewrites would visibly bend the current frame if they were not held back until the boundary.

// File: rtl/rs_frame_seq_pkg.sv
package rs_frame_seq_pkg;

  typedef enum logic [1:0] {
    MODE_PROG  = 2'd0,
    MODE_INTER = 2'd1,
    MODE_SUB   = 2'd2,
    MODE_ALT   = 2'd3
  } scanMode_t;

  typedef struct packed {
    logic rowStart;  // first enabled cycle of a row slot
    logic xferStb;   // transfer strobe of a readout row
    logic shiftOn;   // shift-out phase of a readout row
    logic frameEnd;  // last enabled cycle of the frame
  } ctlStb_t;

endpackage

// File: rtl/rs_frame_seq_ctl.sv
module rs_frame_seq_ctl
  import rs_frame_seq_pkg::*;
#(
  parameter int ROP_CYCLES  = 780,
  parameter int XFER_CYCLES = 40,
  parameter int RDLY_W      = 11,
  parameter int SLOT_W      = 15,
  parameter int PH_W        = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [RDLY_W-1:0] rowDlyQ,
  input  logic [SLOT_W-1:0] slotTotal,
  input  logic [SLOT_W-1:0] nReadCur,
  output ctlStb_t           stb,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              frameStart
);

  logic [PH_W-1:0]   pCnt;
  logic [SLOT_W-1:0] sCnt;
  logic [PH_W-1:0]   rowLast;
  logic [PH_W-1:0]   shiftFrom;
  logic              rowEnd;
  logic              lastSlot;
  logic              realRow;

  always_comb begin
    rowLast   = PH_W'(ROP_CYCLES - 1) + PH_W'(rowDlyQ);
    shiftFrom = PH_W'(rowDlyQ) + PH_W'(XFER_CYCLES);
    rowEnd    = (pCnt == rowLast);
    lastSlot  = ({1'b0, sCnt} + 1'b1) >= {1'b0, slotTotal};
    realRow   = sCnt < nReadCur;
    stb.rowStart = ce && (pCnt == '0);
    stb.xferStb  = ce && realRow && (pCnt == PH_W'(rowDlyQ));
    stb.shiftOn  = realRow && (pCnt >= shiftFrom);
    stb.frameEnd = ce && rowEnd && lastSlot;
    frameStart   = ce && (pCnt == '0) && (sCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pCnt <= '0;
      sCnt <= '0;
    end else if (ce) begin
      if (rowEnd) begin
        pCnt <= '0;
        sCnt <= lastSlot ? '0 : sCnt + 1'b1;
      end else begin
        pCnt <= pCnt + 1'b1;
      end
    end
  end

  assign slotIdx = sCnt;

  // R1: strobes only on enabled cycles
  p_ce_gate_r1: assert property (@(posedge clk) disable iff (rst)
    !ce |-> (!stb.xferStb && !stb.rowStart && !frameStart));

  // R2: transfer and shift-out never overlap
  p_xfer_excl_r2: assert property (@(posedge clk) disable iff (rst)
    stb.xferStb |-> !stb.shiftOn);

  // R4: a frame end lands on slot zero with no shift-out
  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    stb.frameEnd |=> (slotIdx == '0 && !stb.shiftOn));

endmodule

// File: rtl/rs_frame_seq_dp.sv
module rs_frame_seq_dp
  import rs_frame_seq_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int RDLY_W  = 11,
  parameter int FDLY_W  = 13,
  parameter int ITIME_W = 14,
  parameter int SLOT_W  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ROW_W-1:0]   winStart,
  input  logic [ROW_W-1:0]   winEnd,
  input  logic [RDLY_W-1:0]  rowDly,
  input  logic [FDLY_W-1:0]  frmDly,
  input  logic [ITIME_W-1:0] intRows,
  input  logic [1:0]         scanMode,
  input  ctlStb_t            stb,
  input  logic [SLOT_W-1:0]  slotIdx,
  output logic [RDLY_W-1:0]  rowDlyQ,
  output logic [SLOT_W-1:0]  slotTotal,
  output logic [SLOT_W-1:0]  nReadCur,
  output logic [ROW_W-1:0]   readRow,
  output logic [ROW_W-1:0]   rstRow,
  output logic               rstValid,
  output logic               cfgErr
);

  localparam int N_W   = ROW_W + 1;
  localparam int CMP_W = (ITIME_W > SLOT_W) ? ITIME_W : SLOT_W;

  // live settings
  logic [CMP_W-1:0] nLive, limLive, itEff, leadLive;
  logic             overLive;
  scanMode_t        modeLive;

  // captured settings
  logic [ROW_W-1:0]  startQ;
  logic [N_W-1:0]    nQ;
  logic [FDLY_W-1:0] frmDlyQ;
  logic [SLOT_W-1:0] leadQ;
  scanMode_t         modeQ;
  logic              overQ;
  logic              field;

  logic              nextFld;
  logic [SLOT_W-1:0] nReadNext;
  logic [SLOT_W:0]   sumW;
  logic              wrap;
  logic [SLOT_W-1:0] tgtSlot;

  function automatic logic [SLOT_W-1:0] readsIn(input logic [N_W-1:0] n,
                                                input scanMode_t m, input logic fld);
    logic [SLOT_W-1:0] nw;
    nw = SLOT_W'(n);
    case (m)
      MODE_INTER: return fld ? (nw >> 1) : ((nw + 1'b1) >> 1);
      MODE_SUB:   return (nw + 1'b1) >> 1;
      default:    return nw;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] rowOf(input logic [ROW_W-1:0] base,
                                             input logic [SLOT_W-1:0] k,
                                             input scanMode_t m, input logic fld);
    logic [SLOT_W-1:0] off;
    case (m)
      MODE_INTER: off = (k << 1) + SLOT_W'(fld);
      MODE_SUB:   off = k << 1;
      default:    off = k;
    endcase
    return base + ROW_W'(off);
  endfunction

  always_comb begin
    modeLive = scanMode_t'(scanMode);
    nLive    = CMP_W'(winEnd) - CMP_W'(winStart) + CMP_W'(1);
    case (modeLive)
      MODE_INTER: limLive = nLive + (CMP_W'(frmDly) << 1);
      MODE_SUB:   limLive = nLive + CMP_W'(frmDly >> 1);
      default:    limLive = nLive + CMP_W'(frmDly);
    endcase
    overLive = CMP_W'(intRows) > limLive;
    itEff    = overLive ? limLive : CMP_W'(intRows);
    leadLive = (modeLive == MODE_INTER || modeLive == MODE_SUB) ? (itEff >> 1) : itEff;
  end

  always_ff @(posedge clk) begin
    if (rst || stb.frameEnd) begin
      startQ  <= winStart;
      nQ      <= N_W'(nLive);
      rowDlyQ <= rowDly;
      frmDlyQ <= frmDly;
      leadQ   <= SLOT_W'(leadLive);
      modeQ   <= modeLive;
      overQ   <= overLive;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) field <= 1'b0;
    else if (stb.frameEnd) field <= (modeQ == MODE_INTER) ? ~field : 1'b0;
  end

  always_ff @(posedge clk) begin
    cfgErr <= !rst && (cfgErr || overQ);
  end

  always_comb begin
    nextFld   = (modeQ == MODE_INTER) ? ~field : 1'b0;
    nReadCur  = readsIn(nQ, modeQ, field);
    nReadNext = readsIn(nQ, modeQ, nextFld);
    slotTotal = nReadCur + SLOT_W'(frmDlyQ);
    readRow   = rowOf(startQ, slotIdx, modeQ, field);
    sumW      = {1'b0, slotIdx} + {1'b0, leadQ};
    wrap      = sumW >= {1'b0, slotTotal};
    tgtSlot   = wrap ? SLOT_W'(sumW - {1'b0, slotTotal}) : SLOT_W'(sumW);
    rstValid  = tgtSlot < (wrap ? nReadNext : nReadCur);
    rstRow    = rowOf(startQ, tgtSlot, modeQ, wrap ? nextFld : field);
  end

  // R10: error flag is sticky until reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    cfgErr |=> cfgErr);

  // R9: clamped lead never reaches beyond one frame of slots
  p_lead_clamp_r9: assert property (@(posedge clk) disable iff (rst)
    leadQ <= slotTotal);

  // R3: rows read out stay inside the captured window
  p_read_window_r3: assert property (@(posedge clk) disable iff (rst)
    (stb.shiftOn || stb.xferStb) |-> ({1'b0, ROW_W'(readRow - startQ)} < nQ));

  // R8: reset targets stay inside the captured window
  p_rst_window_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.rowStart && rstValid) |-> ({1'b0, ROW_W'(rstRow - startQ)} < nQ));

endmodule

// File: rtl/rs_frame_seq.sv
module rs_frame_seq
  import rs_frame_seq_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int RDLY_W      = 11,
  parameter int FDLY_W      = 13,
  parameter int ITIME_W     = 14,
  parameter int ROP_CYCLES  = 780,
  parameter int XFER_CYCLES = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic [ROW_W-1:0]   winStart,
  input  logic [ROW_W-1:0]   winEnd,
  input  logic [RDLY_W-1:0]  rowDly,
  input  logic [FDLY_W-1:0]  frmDly,
  input  logic [ITIME_W-1:0] intRows,
  input  logic [1:0]         scanMode,
  output logic [ROW_W-1:0]   readRow,
  output logic [ROW_W-1:0]   resetRow,
  output logic               xferStb,
  output logic               lineValid,
  output logic               rowRstStb,
  output logic               frameStart,
  output logic               cfgErr
);

  localparam int N_W    = ROW_W + 1;
  localparam int SLOT_W = ((N_W > FDLY_W) ? N_W : FDLY_W) + 2;
  localparam int PH_W   = $clog2(ROP_CYCLES + (1 << RDLY_W));

  ctlStb_t           stb;
  logic [SLOT_W-1:0] slotIdx, slotTotal, nReadCur;
  logic [RDLY_W-1:0] rowDlyQ;
  logic              rstValid;

  rs_frame_seq_ctl #(
    .ROP_CYCLES(ROP_CYCLES), .XFER_CYCLES(XFER_CYCLES),
    .RDLY_W(RDLY_W), .SLOT_W(SLOT_W), .PH_W(PH_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .ce(ce), .rowDlyQ(rowDlyQ),
    .slotTotal(slotTotal), .nReadCur(nReadCur),
    .stb(stb), .slotIdx(slotIdx), .frameStart(frameStart)
  );

  rs_frame_seq_dp #(
    .ROW_W(ROW_W), .RDLY_W(RDLY_W), .FDLY_W(FDLY_W),
    .ITIME_W(ITIME_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .winStart(winStart), .winEnd(winEnd),
    .rowDly(rowDly), .frmDly(frmDly), .intRows(intRows), .scanMode(scanMode),
    .stb(stb), .slotIdx(slotIdx), .rowDlyQ(rowDlyQ), .slotTotal(slotTotal),
    .nReadCur(nReadCur), .readRow(readRow), .rstRow(resetRow),
    .rstValid(rstValid), .cfgErr(cfgErr)
  );

  assign xferStb   = stb.xferStb;
  assign lineValid = stb.shiftOn;
  assign rowRstStb = stb.rowStart && rstValid;

  // R8: reset strobe is issued only on the opening cycle of a slot
  p_rst_on_row_start_r8: assert property (@(posedge clk) disable iff (rst)
    rowRstStb |-> !lineValid);

endmodule

// File: tb/rs_frame_seq_tb.sv
`timescale 1ns/1ps
module rs_frame_seq_tb;

  localparam int ROW_W = 6, RDLY_W = 4, FDLY_W = 4, ITIME_W = 7;
  localparam int ROP = 12, XFER = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst = 1'b1, ce = 1'b0;
  logic [ROW_W-1:0]   winStart = '0, winEnd = '0;
  logic [RDLY_W-1:0]  rowDly = '0;
  logic [FDLY_W-1:0]  frmDly = '0;
  logic [ITIME_W-1:0] intRows = '0;
  logic [1:0]         scanMode = '0;
  logic [ROW_W-1:0]   readRow, resetRow;
  logic               xferStb, lineValid, rowRstStb, frameStart, cfgErr;

  rs_frame_seq #(.ROW_W(ROW_W), .RDLY_W(RDLY_W), .FDLY_W(FDLY_W), .ITIME_W(ITIME_W),
                 .ROP_CYCLES(ROP), .XFER_CYCLES(XFER)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .winStart(winStart), .winEnd(winEnd),
    .rowDly(rowDly), .frmDly(frmDly), .intRows(intRows), .scanMode(scanMode),
    .readRow(readRow), .resetRow(resetRow), .xferStb(xferStb), .lineValid(lineValid),
    .rowRstStb(rowRstStb), .frameStart(frameStart), .cfgErr(cfgErr));

  // stimulus settings applied at the next negedge
  int sStart, sEnd, sRd, sFd, sIt, sMode, sRst, ceRand;
  logic [15:0] lfsr = 16'hACE1;

  int nChecks = 0, nFail = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  int cStart, cRd, cFd, cLead, cMode, p, s, field;
  bit cOver, err;
  int curRows[$], nxtRows[$];

  function automatic int nrd(int n, int m, int f);
    if (m == 1) return f ? n / 2 : (n + 1) / 2;
    if (m == 2) return (n + 1) / 2;
    return n;
  endfunction

  function automatic int rowAt(int base, int k, int m, int f);
    int off;
    off = (m == 1) ? 2 * k + f : (m == 2) ? 2 * k : k;
    return (base + off) % (1 << ROW_W);
  endfunction

  task automatic latch();
    int n, lim, ite, nf;
    cStart = sStart; cRd = sRd; cFd = sFd; cMode = sMode;
    n = sEnd - sStart + 1;
    lim = (sMode == 1) ? n + 2 * sFd : (sMode == 2) ? n + sFd / 2 : n + sFd;
    cOver = sIt > lim;
    ite = cOver ? lim : sIt;
    cLead = (sMode == 1 || sMode == 2) ? ite / 2 : ite;
    nf = (cMode == 1) ? 1 - field : 0;
    curRows.delete(); nxtRows.delete();
    for (int k = 0; k < nrd(n, cMode, field); k++) curRows.push_back(rowAt(cStart, k, cMode, field));
    for (int k = 0; k < nrd(n, cMode, nf); k++) nxtRows.push_back(rowAt(cStart, k, cMode, nf));
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    int total, q, expRr;
    bit real_, expX, expLv, expFs, expRs;
    total = curRows.size() + cFd;
    real_ = s < curRows.size();
    expX  = ce && real_ && p == cRd;
    expLv = real_ && p >= cRd + XFER;
    expFs = ce && s == 0 && p == 0;
    q = s + cLead;
    expRs = 0; expRr = 0;
    if (q >= total) begin
      q -= total;
      if (q < nxtRows.size()) begin expRs = 1; expRr = nxtRows[q]; end
    end else if (q < curRows.size()) begin
      expRs = 1; expRr = curRows[q];
    end
    expRs = expRs && ce && p == 0;
    chk(frameStart == expFs, "R4 frameStart", int'(frameStart), int'(expFs));
    chk(xferStb == expX, "R1 R2 xferStb", int'(xferStb), int'(expX));
    chk(lineValid == expLv, "R2 R4 lineValid", int'(lineValid), int'(expLv));
    if (expX || expLv)
      chk(int'(readRow) == curRows[s], "R3 R5 R6 R7 readRow", int'(readRow), curRows[s]);
    chk(rowRstStb == expRs, "R8 rowRstStb", int'(rowRstStb), int'(expRs));
    if (expRs)
      chk(int'(resetRow) == expRr, "R8 R9 resetRow", int'(resetRow), expRr);
    chk(cfgErr == err, "R10 cfgErr", int'(cfgErr), int'(err));
  endtask

  task automatic step();
    if (rst) begin
      field = 0; p = 0; s = 0; err = 0;
      latch();
    end else begin
      if (cOver) err = 1;
      if (ce) begin
        if (p == ROP + cRd - 1) begin
          p = 0;
          if (s + 1 >= curRows.size() + cFd) begin
            s = 0;
            field = (cMode == 1) ? 1 - field : 0;
            latch();
          end else s++;
        end else p++;
      end
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst = sRst[0];
      ce = ceRand ? (lfsr[1:0] != 2'b00) : 1'b1;
      winStart = ROW_W'(sStart); winEnd = ROW_W'(sEnd);
      rowDly = RDLY_W'(sRd); frmDly = FDLY_W'(sFd);
      intRows = ITIME_W'(sIt); scanMode = 2'(sMode);
      #1;
      if (!rst) compare();
      step();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      summary();
      $finish;
    end
  end

  initial begin
    // R3 R4 R8: progressive, reset state then several frames
    sStart = 2; sEnd = 6; sRd = 2; sFd = 1; sIt = 3; sMode = 0; ceRand = 0;
    sRst = 1; cyc(3); sRst = 0; cyc(600);
    // R7 R1: mid-frame rewrite with irregular enable, zero delays
    cyc(37); sStart = 10; sEnd = 13; sRd = 0; sFd = 0; sIt = 0; ceRand = 1; cyc(500);
    // R5 R8: alternating fields, lead wraps into the other field
    sStart = 4; sEnd = 9; sRd = 1; sFd = 2; sIt = 8; sMode = 1; ceRand = 0; cyc(900);
    // R6 R9 R10: every other row, lead above limit then legal
    sStart = 0; sEnd = 4; sRd = 3; sFd = 3; sIt = 40; sMode = 2; cyc(500);
    sIt = 2; cyc(400);
    // R10: reset clears the flag; one-row window, reserved mode
    sRst = 1; cyc(2); sRst = 0;
    sStart = 20; sEnd = 20; sRd = 0; sFd = 2; sIt = 3; sMode = 0; cyc(300);
    sMode = 3; sIt = 1; ceRand = 1; cyc(300);
    // R1 R9: largest delays with lead clamp, restarted by reset
    sRst = 1; cyc(2); sRst = 0;
    sStart = 30; sEnd = 40; sRd = 15; sFd = 15; sIt = 127; sMode = 0; ceRand = 0; cyc(900);
    sMode = 1; sIt = 20; ceRand = 1; cyc(1200);
    finished = 1;
    summary();
    $finish;
  end

endmodule